// File: doc/BRIEF.md
# Packed Receive Frame Writer

This block sits between a receive MAC and the host-memory write path. It packs every received Ethernet frame into one contiguous byte stream. No per-frame descriptor is used. Each frame is stored in a small local frame memory while it arrives. When the frame ends, the block writes a two-byte tag at the current write pointer and then writes the payload bytes straight after it. The tag holds the byte count and a flag that says whether the MAC reported a good checksum. The next frame begins at the byte after the last payload byte, with no padding in between.

The host buffer is a window of `BUF_BYTES` bytes. Before a frame is placed, the block checks that the frame fits and that two bytes still remain after it. If not, the block writes a zero tag, which the reader treats as "no more frames here", and pulses `buf_done`. It then places the frame at offset 0 of the next window.

The input is one byte per cycle. `in_sof` marks the first byte of a frame, and `in_eof` marks the last byte together with `in_fcs_ok`. The block has no backpressure. A frame that starts while the previous one is still being written out is discarded. `BUF_BYTES` must be at least `MAX_LEN + 4`.

Top module: `pkt_stream_framer`

## Requirements
- R1: For each frame the block writes a two-byte tag at the current write pointer. The byte at the pointer holds length bits 7:0. The byte at pointer+1 holds length bits 14:8 in bits 6:0 and the checksum flag in bit 7.
- R2: The payload bytes follow the tag at consecutive addresses, in arrival order. `wr_ptr` then advances by exactly 2 + length, with no padding. Every write address is below `BUF_BYTES`.
- R3: The tag's checksum flag (bit 7 of the second byte) equals `in_fcs_ok` as sampled with `in_eof`.
- R4: A frame longer than `MAX_LEN` bytes is stored as its first `MAX_LEN` bytes. Its tag length is `MAX_LEN` and its checksum flag is 0.
- R5: If `BUF_BYTES - wr_ptr` is less than length + 4, the block writes 0x00 at `wr_ptr` and 0x00 at `wr_ptr`+1, and pulses `buf_done` with the second of these bytes. It then places the frame at offset 0.
- R6: If `BUF_BYTES - wr_ptr` equals length + 4 exactly, the frame is placed at `wr_ptr` and no terminator is written.
- R7: A frame whose first byte arrives while the previous frame is still held or being written is dropped completely. It causes no writes, and its end marker does not complete anything.
- R8: Bytes with `in_valid` high that are not inside a frame opened by `in_sof` are ignored. They cause no writes and do not move the pointer.
- R9: After reset, `wr_valid` and `buf_done` are 0 and `wr_ptr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_fcs_ok | input | 1 | Checksum good, sampled with in_eof |
| wr_valid | output | 1 | Output write strobe |
| wr_addr | output | $clog2(BUF_BYTES) | Byte offset of the write in the buffer |
| wr_data | output | 8 | Byte to write |
| wr_ptr | output | $clog2(BUF_BYTES) | Next free offset in the buffer |
| buf_done | output | 1 | Buffer closed; pulses with the second terminator byte |

## Verification
A wrong length count shows up at the ports straight away. The tag byte carries the wrong value, and `wr_ptr` ends the frame with the wrong stride, so the error is visible by the last payload write of that same frame. A wrong room decision shows up in the next frame's first write. That write lands past the window end, or a zero tag appears where a frame still fits (or is missing where one does not). A frame-held flag that never clears shows up as every later frame being dropped, which leaves `wr_ptr` frozen. An off-by-one in the read-ahead address shows up as every payload byte shifted by one position.

// File: rtl/pkt_framer_pkg.sv
package pkt_framer_pkg;
  localparam int TAG_BYTES  = 2;
  localparam int TERM_BYTES = 2;
  localparam int LEN_W      = 15;

  typedef enum logic [2:0] {
    EM_IDLE,
    EM_TERM0,
    EM_TERM1,
    EM_TAG0,
    EM_TAG1,
    EM_BODY
  } emit_state_e;
endpackage

// File: rtl/psf_frame_ram.sv
module psf_frame_ram #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/psf_capture.sv
module psf_capture
  import pkt_framer_pkg::*;
#(
  parameter int MAX_LEN = 1518,
  parameter int AW      = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             in_fcs_ok,
  input  logic             release_i,
  output logic             ram_we,
  output logic [AW-1:0]    ram_waddr,
  output logic [7:0]       ram_wdata,
  output logic             ready_o,
  output logic [LEN_W-1:0] len_o,
  output logic             fcs_o
);
  logic             active;
  logic             trunc;
  logic [LEN_W-1:0] cnt;
  logic             take;
  logic             store;
  logic [LEN_W-1:0] cnt_base;
  logic [LEN_W-1:0] new_cnt;
  logic             trunc_base;
  logic             trunc_next;

  // A new frame may open only when nothing is held; continuation bytes need an open frame.
  assign take       = in_valid && (in_sof ? !ready_o : active);
  assign cnt_base   = in_sof ? '0 : cnt;
  assign trunc_base = in_sof ? 1'b0 : trunc;
  assign store      = take && (int'(cnt_base) < MAX_LEN);
  assign new_cnt    = cnt_base + LEN_W'(store);
  assign trunc_next = trunc_base | (take && !store);

  assign ram_we    = store;
  assign ram_waddr = cnt_base[AW-1:0];
  assign ram_wdata = in_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      trunc   <= 1'b0;
      cnt     <= '0;
      ready_o <= 1'b0;
      len_o   <= '0;
      fcs_o   <= 1'b0;
    end else begin
      if (release_i) ready_o <= 1'b0;
      if (take) begin
        cnt   <= new_cnt;
        trunc <= trunc_next;
        if (in_eof) begin
          active  <= 1'b0;
          ready_o <= 1'b1;
          len_o   <= new_cnt;
          fcs_o   <= in_fcs_ok && !trunc_next;
        end else begin
          active <= 1'b1;
        end
      end else if (in_valid && in_sof) begin
        active <= 1'b0;
      end
    end
  end

  assert_len_range_R4: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> (int'(len_o) <= MAX_LEN && len_o != '0));
  assert_held_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (ready_o && !release_i) |=> ($stable(len_o) && $stable(fcs_o) && ready_o));
  assert_no_store_while_held_R7: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> !ram_we);
endmodule

// File: rtl/psf_emitter.sv
module psf_emitter
  import pkt_framer_pkg::*;
#(
  parameter int BUF_BYTES = 4096,
  parameter int AW        = 11,
  localparam int PW = $clog2(BUF_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ready_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             fcs_i,
  output logic             release_o,
  output logic [AW-1:0]    ram_raddr,
  input  logic [7:0]       ram_rdata,
  output logic             wr_valid,
  output logic [PW-1:0]    wr_addr,
  output logic [7:0]       wr_data,
  output logic [PW-1:0]    wr_ptr,
  output logic             buf_done
);
  emit_state_e      state;
  logic [PW-1:0]    ptr;
  logic [LEN_W-1:0] idx;
  logic [LEN_W-1:0] idx_next;
  logic             no_room;

  assign no_room   = (BUF_BYTES - int'(ptr)) < (int'(len_i) + TAG_BYTES + TERM_BYTES);
  assign idx_next  = idx + LEN_W'(1);
  // Read one byte ahead so the registered memory output lines up with the body write.
  assign ram_raddr = (state == EM_BODY) ? idx_next[AW-1:0] : '0;
  assign wr_ptr    = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= EM_IDLE;
      ptr       <= '0;
      idx       <= '0;
      wr_valid  <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      buf_done  <= 1'b0;
      release_o <= 1'b0;
    end else begin
      wr_valid  <= 1'b0;
      buf_done  <= 1'b0;
      release_o <= 1'b0;
      case (state)
        EM_IDLE: begin
          if (ready_i && !release_o) state <= no_room ? EM_TERM0 : EM_TAG0;
        end
        EM_TERM0: begin
          wr_valid <= 1'b1;
          wr_addr  <= ptr;
          wr_data  <= 8'h00;
          state    <= EM_TERM1;
        end
        EM_TERM1: begin
          wr_valid <= 1'b1;
          wr_addr  <= ptr + PW'(1);
          wr_data  <= 8'h00;
          buf_done <= 1'b1;
          ptr      <= '0;
          state    <= EM_TAG0;
        end
        EM_TAG0: begin
          wr_valid <= 1'b1;
          wr_addr  <= ptr;
          wr_data  <= len_i[7:0];
          ptr      <= ptr + PW'(1);
          state    <= EM_TAG1;
        end
        EM_TAG1: begin
          wr_valid <= 1'b1;
          wr_addr  <= ptr;
          wr_data  <= {fcs_i, len_i[14:8]};
          ptr      <= ptr + PW'(1);
          idx      <= '0;
          state    <= EM_BODY;
        end
        EM_BODY: begin
          wr_valid <= 1'b1;
          wr_addr  <= ptr;
          wr_data  <= ram_rdata;
          ptr      <= ptr + PW'(1);
          idx      <= idx_next;
          if (idx_next == len_i) begin
            release_o <= 1'b1;
            state     <= EM_IDLE;
          end
        end
        default: state <= EM_IDLE;
      endcase
    end
  end

  assert_addr_in_window_R2: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (int'(wr_addr) < BUF_BYTES));
  assert_contiguous_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !buf_done) |=> (!wr_valid || wr_addr == $past(wr_addr) + PW'(1)));
  assert_term_pair_R5: assert property (@(posedge clk) disable iff (rst)
    buf_done |-> ($past(wr_valid) && $past(wr_data) == 8'h00 && wr_data == 8'h00));
  assert_restart_at_zero_R5: assert property (@(posedge clk) disable iff (rst)
    buf_done |=> (wr_valid && wr_addr == '0));
endmodule

// File: rtl/pkt_stream_framer.sv
module pkt_stream_framer
  import pkt_framer_pkg::*;
#(
  parameter int MAX_LEN   = 1518,
  parameter int BUF_BYTES = 4096,
  localparam int AW = $clog2(MAX_LEN),
  localparam int PW = $clog2(BUF_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic          in_fcs_ok,
  output logic          wr_valid,
  output logic [PW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic [PW-1:0] wr_ptr,
  output logic          buf_done
);
  logic             ram_we;
  logic [AW-1:0]    ram_waddr;
  logic [7:0]       ram_wdata;
  logic [AW-1:0]    ram_raddr;
  logic [7:0]       ram_rdata;
  logic             held;
  logic [LEN_W-1:0] held_len;
  logic             held_fcs;
  logic             release_s;

  psf_capture #(.MAX_LEN(MAX_LEN), .AW(AW)) u_capture (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof),
    .in_eof(in_eof), .in_fcs_ok(in_fcs_ok),
    .release_i(release_s),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .ready_o(held), .len_o(held_len), .fcs_o(held_fcs)
  );

  psf_frame_ram #(.DEPTH(1 << AW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  psf_emitter #(.BUF_BYTES(BUF_BYTES), .AW(AW)) u_emitter (
    .clk(clk), .rst(rst),
    .ready_i(held), .len_i(held_len), .fcs_i(held_fcs),
    .release_o(release_s),
    .ram_raddr(ram_raddr), .ram_rdata(ram_rdata),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ptr(wr_ptr), .buf_done(buf_done)
  );

  assert_reset_quiet_R9: assert property (@(posedge clk)
    $past(rst) |-> (!wr_valid && !buf_done && wr_ptr == '0));
endmodule

// File: tb/pkt_stream_framer_bench.sv
module pkt_stream_framer_bench;
  localparam int MAXL = 40;
  localparam int BUFB = 128;
  localparam int PW   = $clog2(BUFB);
  localparam int NVEC = 8;
  // Each entry: {checksum good, length[7:0]}
  localparam logic [8:0] VEC [NVEC] = '{
    {1'b1, 8'd10}, {1'b0, 8'd1},  {1'b1, 8'd40}, {1'b1, 8'd30},
    {1'b1, 8'd20}, {1'b1, 8'd15}, {1'b0, 8'd25}, {1'b1, 8'd3}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_fcs_ok = 1'b0;
  logic [7:0] in_data = '0;
  logic wr_valid, buf_done;
  logic [PW-1:0] wr_addr, wr_ptr;
  logic [7:0] wr_data;

  int checks = 0, errors = 0;
  int exp_ptr = 0, exp_done = 0;
  int nwrites = 0, ndone = 0;
  logic [7:0] shadow [BUFB];

  always #10 clk = ~clk;

  pkt_stream_framer #(.MAX_LEN(MAXL), .BUF_BYTES(BUFB)) u_pkt_stream_framer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .in_fcs_ok(in_fcs_ok),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ptr(wr_ptr), .buf_done(buf_done)
  );

  always @(negedge clk) begin
    if (!rst && wr_valid) begin
      shadow[wr_addr] = wr_data;
      nwrites++;
    end
    if (!rst && buf_done) ndone++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fill_shadow();
    for (int i = 0; i < BUFB; i++) shadow[i] = 8'hAA;
  endtask

  task automatic send(input int len, input bit fcs, input int seed, input bit open);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid  = 1'b1;
      in_data   = 8'((seed + i) & 255);
      in_sof    = open && (i == 0);
      in_eof    = (i == len - 1);
      in_fcs_ok = fcs;
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_fcs_ok = 1'b0;
  endtask

  task automatic settle();
    repeat (2 * MAXL + 20) @(negedge clk);
  endtask

  task automatic expect_frame(input int len_in, input bit fcs, input int seed);
    int l;
    bit f;
    int bad;
    l = (len_in > MAXL) ? MAXL : len_in;
    f = fcs && (len_in <= MAXL);
    if (BUFB - exp_ptr < l + 4) begin
      // R5: terminator pair then restart at offset zero
      chk(shadow[exp_ptr] == 8'h00 && shadow[exp_ptr + 1] == 8'h00, "R5 terminator bytes",
          int'({shadow[exp_ptr], shadow[exp_ptr + 1]}), 0);
      exp_done++;
      exp_ptr = 0;
    end
    chk(shadow[exp_ptr] == 8'(l), "R1 tag low byte", shadow[exp_ptr], l & 255);
    chk(shadow[exp_ptr + 1] == {f, 7'(l >> 8)}, "R1 R3 R4 tag high byte",
        shadow[exp_ptr + 1], int'({f, 7'(l >> 8)}));
    bad = 0;
    for (int i = 0; i < l; i++)
      if (shadow[exp_ptr + 2 + i] != 8'((seed + i) & 255)) bad++;
    chk(bad == 0, "R2 payload bytes in order", bad, 0);
    exp_ptr = exp_ptr + 2 + l;
    chk(int'(wr_ptr) == exp_ptr, "R2 pointer stride", wr_ptr, exp_ptr);
    chk(ndone == exp_done, "R5 buffer-complete pulses", ndone, exp_done);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(wr_ptr == '0, "R9 pointer after reset", wr_ptr, 0);
    chk(!wr_valid && !buf_done, "R9 strobes after reset", {wr_valid, buf_done}, 0);
    exp_ptr = 0;
    exp_done = ndone;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int w0;
    do_reset();

    // Table-driven walk: R1 R2 R3 and an R5 wrap inside the sequence
    for (int v = 0; v < NVEC; v++) begin
      fill_shadow();
      send(int'(VEC[v][7:0]), VEC[v][8], v * 17, 1'b1);
      settle();
      expect_frame(int'(VEC[v][7:0]), VEC[v][8], v * 17);
    end

    // R4: oversized frame truncated and flag cleared
    fill_shadow();
    send(MAXL + 5, 1'b1, 200, 1'b1);
    settle();
    expect_frame(MAXL + 5, 1'b1, 200);

    // R7: second frame starts right after the first ends and is dropped
    fill_shadow();
    w0 = nwrites;
    send(5, 1'b1, 60, 1'b1);
    send(6, 1'b1, 90, 1'b1);
    settle();
    chk(nwrites - w0 == 7, "R7 only first frame written", nwrites - w0, 7);
    expect_frame(5, 1'b1, 60);
    fill_shadow();
    send(4, 1'b0, 33, 1'b1);
    settle();
    expect_frame(4, 1'b0, 33);

    // R8: bytes with no opening start marker
    w0 = nwrites;
    send(5, 1'b1, 7, 1'b0);
    settle();
    chk(nwrites == w0, "R8 stray bytes cause no writes", nwrites - w0, 0);
    chk(int'(wr_ptr) == exp_ptr, "R8 pointer unchanged", wr_ptr, exp_ptr);

    // R6: exact fit after reset (0 -> 42 -> 84 -> 126), then R5 at the very end
    do_reset();
    for (int k = 0; k < 3; k++) begin
      fill_shadow();
      send(MAXL, 1'b1, k * 5, 1'b1);
      settle();
      expect_frame(MAXL, 1'b1, k * 5);
    end
    chk(int'(wr_ptr) == BUFB - 2, "R6 exact fit, no terminator", wr_ptr, BUFB - 2);
    fill_shadow();
    send(5, 1'b1, 111, 1'b1);
    settle();
    expect_frame(5, 1'b1, 111);
    chk(exp_done == ndone && int'(wr_ptr) == 7, "R5 wrap from window end", wr_ptr, 7);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule